// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps return addresses for a processor core. On a subroutine call, or when an interrupt diverts execution to its vector, the sequencer raises a push strobe together with the address to return to. On a return of any kind (plain, returning a literal, or leaving an interrupt) it raises a pop strobe. The entry currently on top is always driven on the output, so the fetch unit can take the return target in the same cycle as it decodes the return.

The storage is a ring of eight 13-bit entries, kept apart from program and data memory. The stack pointer is internal. Nothing outside can read or load it. The ring has no notion of full or empty. Pushes beyond the depth silently replace the oldest entries, and pops beyond the depth silently wrap around to stale entries. No overflow or underflow flag is produced.

Top module: `ret_ring_stack`

## Requirements
- R1: One cycle after a push (with no pop), `top_addr_o` equals the pushed `push_addr_i`.
- R2: One cycle after a pop (with no push), `top_addr_o` shows the entry that was on top before the most recent push still in the ring, so addresses leave in reverse order of arrival.
- R3: Eight pushes of distinct addresses followed by eight pops present those addresses on `top_addr_o` in exactly reverse order.
- R4: The ninth push after reset replaces the first pushed entry. After pushes A0..A8 and then eight pops, `top_addr_o` shows A8 and not A0.
- R5: A pop with nothing pushed wraps the pointer backwards modulo 8 and presents whatever entry is stored at that position. No error indication is produced.
- R6: Reset returns the pointer to its initial position and leaves entry contents unchanged. After eight pushes A0..A7 and a reset, `top_addr_o` shows A7 (the last position of the ring). The next push lands in the first position.
- R7: Push and pop asserted together overwrite the top entry with `push_addr_i` and leave the pointer unchanged. A later pop then reveals the same entry it would have revealed without the combined operation.
- R8: With neither strobe asserted, `top_addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the pointer |
| push_i | input | 1 | Push strobe: store `push_addr_i` as the new top |
| pop_i | input | 1 | Pop strobe: discard the top entry |
| push_addr_i | input | 13 | Return address to store |
| top_addr_o | output | 13 | Current top entry |

## Verification
The bench builds the block with its default parameters: eight entries of 13 bits each. A ring of eight is short enough that random push/pop sequences pass the wrap point many times, in both directions. Every overwrite of the oldest entry, every wrapped pop and every combined push-pop at the ring seam therefore occurs often within a few thousand cycles. Directed sequences fix the exact ninth-push, reset-keeps-contents and empty-pop cases against hand-derived addresses.

// File: rtl/ret_ring_pkg.sv
package ret_ring_pkg;

    // Operation requested in one cycle, decoded from the two strobes.
    typedef enum logic [1:0] {
        RING_IDLE = 2'b00,
        RING_PUSH = 2'b01,
        RING_POP  = 2'b10,
        RING_SWAP = 2'b11
    } ring_op_e;

    // Write request handed from the pointer unit to the entry bank.
    typedef struct packed {
        logic       en;
        logic [7:0] idx;
    } ring_wr_t;

    function automatic ring_op_e ring_decode(input logic push, input logic pop);
        ring_op_e op;
        case ({pop, push})
            2'b01:   op = RING_PUSH;
            2'b10:   op = RING_POP;
            2'b11:   op = RING_SWAP;
            default: op = RING_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/ret_ring_ptr.sv
module ret_ring_ptr
    import ret_ring_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ring_op_e                   op_i,
    output logic [$clog2(DEPTH)-1:0]   top_idx_o,
    output ring_wr_t                   wr_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end

    always_comb begin
        ptr_d   = ptr_q;
        wr_o.en = 1'b0;
        wr_o.idx = 8'(ptr_q);
        case (op_i)
            RING_PUSH: begin
                ptr_d    = ptr_inc;
                wr_o.en  = 1'b1;
                wr_o.idx = 8'(ptr_inc);
            end
            RING_POP: ptr_d = ptr_dec;
            RING_SWAP: begin
                wr_o.en  = 1'b1;
                wr_o.idx = 8'(ptr_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= LAST;
        else     ptr_q <= ptr_d;
    end

    assign top_idx_o = ptr_q;

    // R6
    ptr_reset_chk: assert property (@(posedge clk) rst |=> ptr_q == LAST);

    // R7
    ptr_swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == RING_SWAP |=> $stable(ptr_q));

    // R5
    ptr_pop_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == RING_POP && ptr_q == '0) |=> ptr_q == LAST);

    // R4
    ptr_push_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == RING_PUSH && ptr_q == LAST) |=> ptr_q == '0);

endmodule

// File: rtl/ret_ring_bank.sv
module ret_ring_bank
    import ret_ring_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 13
) (
    input  logic                       clk,
    input  ring_wr_t                   wr_i,
    input  logic [WIDTH-1:0]           wr_data_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
    output logic [WIDTH-1:0]           rd_data_o
);
    logic [WIDTH-1:0] entry_q [DEPTH];

    // Entries have no reset: contents survive a pointer reset.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic hit;
        assign hit = wr_i.en && (wr_i.idx == 8'(i));
        always_ff @(posedge clk) begin
            if (hit) entry_q[i] <= wr_data_i;
        end
    end

    assign rd_data_o = entry_q[rd_idx_i];

    // R1
    bank_write_land_chk: assert property (@(posedge clk)
        wr_i.en |=> entry_q[$past(wr_i.idx[$clog2(DEPTH)-1:0])] == $past(wr_data_i));

endmodule

// File: rtl/ret_ring_stack.sv
module ret_ring_stack
    import ret_ring_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_addr_i,
    output logic [WIDTH-1:0] top_addr_o
);
    localparam int PTR_W = $clog2(DEPTH);

    ring_op_e          op;
    ring_wr_t          wr;
    logic [PTR_W-1:0]  top_idx;

    assign op = ring_decode(push_i, pop_i);

    ret_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .top_idx_o (top_idx),
        .wr_o      (wr)
    );

    ret_ring_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk       (clk),
        .wr_i      (wr),
        .wr_data_i (push_addr_i),
        .rd_idx_i  (top_idx),
        .rd_data_o (top_addr_o)
    );

    // R1
    top_after_push_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |=> top_addr_o == $past(push_addr_i));

    // R8
    top_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i) |=> $stable(top_addr_o));

endmodule

// File: tb/ret_ring_stack_bench.sv
module ret_ring_stack_bench;
    localparam int DEPTH = 8;
    localparam int WIDTH = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] push_addr_i = '0;
    logic [WIDTH-1:0] top_addr_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [WIDTH-1:0] m_mem [DEPTH];
    int               m_ptr = DEPTH - 1;
    logic [WIDTH-1:0] seq [9];

    always #10 clk = ~clk;

    ret_ring_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ret_ring_stack (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
        .push_addr_i(push_addr_i), .top_addr_o(top_addr_o)
    );

    function automatic logic [WIDTH-1:0] model_top();
        return m_mem[m_ptr];
    endfunction

    function automatic void model_step(bit p, bit q, logic [WIDTH-1:0] a);
        if (p && q) m_mem[m_ptr] = a;
        else if (p) begin
            m_ptr = (m_ptr + 1) % DEPTH;
            m_mem[m_ptr] = a;
        end else if (q) m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
    endfunction

    task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on the falling edge; the result is visible at the next falling edge.
    task automatic step(bit p, bit q, logic [WIDTH-1:0] a);
        push_i = p; pop_i = q; push_addr_i = a;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        model_step(p, q, a);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ptr = DEPTH - 1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        do_reset();

        // R1 / R3: fill with distinct values
        for (int i = 0; i < 8; i++) begin
            seq[i] = 13'h100 + 13'(i * 7);
            step(1, 0, seq[i]);
            check("R1 push shows top", top_addr_o, seq[i]);
        end
        // R8: idle hold
        step(0, 0, 13'h1FFF);
        check("R8 idle hold", top_addr_o, seq[7]);
        // R2 / R3: reverse order
        for (int i = 6; i >= 0; i--) begin
            step(0, 1, '0);
            check("R3 reverse order", top_addr_o, seq[i]);
        end
        // R5: pop past bottom wraps to last position (holds seq[7])
        step(0, 1, '0);
        check("R5 empty pop wraps", top_addr_o, seq[7]);

        // R4: nine pushes from reset, eight pops
        do_reset();
        for (int i = 0; i < 9; i++) begin
            seq[i] = 13'h0A00 + 13'(i);
            step(1, 0, seq[i]);
        end
        for (int i = 0; i < 7; i++) step(0, 1, '0);
        check("R4 second entry intact", top_addr_o, seq[1]);
        step(0, 1, '0);
        check("R4 ninth push replaced first", top_addr_o, seq[8]);

        // R6: reset keeps contents
        do_reset();
        for (int i = 0; i < 8; i++) begin
            seq[i] = 13'h1200 + 13'(i * 3);
            step(1, 0, seq[i]);
        end
        do_reset();
        check("R6 reset keeps last entry", top_addr_o, seq[7]);
        step(1, 0, 13'h0BEE);
        check("R6 push after reset", top_addr_o, 13'h0BEE);
        step(0, 1, '0);
        check("R6 pop reveals old last entry", top_addr_o, seq[7]);
        step(0, 1, '0);
        check("R6 pop reveals old entry 6", top_addr_o, seq[6]);

        // R7: combined push and pop
        step(1, 0, 13'h0123);
        step(1, 1, 13'h0456);
        check("R7 swap replaces top", top_addr_o, 13'h0456);
        step(0, 1, '0);
        check("R7 pointer unchanged", top_addr_o, seq[6]);

        // Random mix against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            bit p, q;
            r = int'($urandom_range(0, 9));
            p = (r < 4) || (r == 9);
            q = (r >= 4 && r < 8) || (r == 9);
            step(p, q, 13'($urandom));
            if (p && q)      check("R7 random swap", top_addr_o, model_top());
            else if (p)      check("R1 random push", top_addr_o, model_top());
            else if (q)      check("R2 random pop", top_addr_o, model_top());
            else             check("R8 random idle", top_addr_o, model_top());
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule